// File: doc/BRIEF.md
# Cross-Clock Mailbox Register Pair

This block carries single words between two clock domains without going through a FIFO. It holds two word-wide mailbox registers. The outbound mailbox (mail1) is loaded from port A and emptied from port B. The return mailbox (mail2) is loaded from port B and emptied from port A. Each mailbox has an active-low flag in the domain of its writer. A low flag means the mailbox holds a word the other side has not yet taken.

Port A reaches the mailboxes when its select input `a_mbx_sel` is high. Port B reaches them when its two-bit size code `b_size` is 2'b11. Port B has no select pin of its own, so the size code does that job. For either port, `*_wr` high means a write and low means a read, and nothing happens unless `*_en` is high.

The mailbox flag acts as the ready signal for the writer. A write offered while the flag is low is dropped, and the word already in the mailbox stays intact. The writer should hold its word and offer it again once the flag returns high.

Set and clear events cross between the domains as toggle bits through synchronizers of `SYNC_STAGES` flops. A word becomes readable on the far side `SYNC_STAGES` reader edges after it is written. The writer's flag returns high `SYNC_STAGES` writer edges after the read.

Top module: `mbx_pair`

## Requirements
- R1: While `rst_n` is low, and after it is released, both `mbf1_n` and `mbf2_n` are high and both `a_rdata` and `b_rdata` are zero.
- R2: A port A edge with `a_en`=1, `a_wr`=1, `a_mbx_sel`=1 and `mbf1_n`=1 stores `a_wdata` into mail1 and drives `mbf1_n` low after that edge.
- R3: A port A mail1 write while `mbf1_n` is low is ignored, and the word already held in mail1 is the one port B later reads.
- R4: A port B edge with `b_en`=1, `b_wr`=0, `b_size`=2'b11, at which the mail1 word is visible to port B, loads that word into `b_rdata` and starts the release of `mbf1_n`.
- R5: A port B edge with `b_en`=1, `b_wr`=1, `b_size`=2'b11 and `mbf2_n`=1 stores `b_wdata` into mail2 and drives `mbf2_n` low after that edge.
- R6: A port B mail2 write while `mbf2_n` is low is ignored, and the word already held in mail2 is the one port A later reads.
- R7: A port A edge with `a_en`=1, `a_wr`=0, `a_mbx_sel`=1, at which the mail2 word is visible to port A, loads that word into `a_rdata` and starts the release of `mbf2_n`.
- R8: Port A accesses with `a_mbx_sel`=0, and port B accesses with `b_size` other than 2'b11, change neither the mailboxes, the flags nor the read outputs.
- R9: A mailbox read issued before a word is visible to the reader leaves that port's read output unchanged and does not release the flag.
- R10: After a mail1 read, `mbf1_n` is still low after one further port A edge, and it is high again by the fourth port A edge (with `SYNC_STAGES`=2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock, unrelated to clk_a |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| a_en | input | 1 | Port A access enable |
| a_wr | input | 1 | Port A direction: 1 write, 0 read |
| a_mbx_sel | input | 1 | Port A mailbox select |
| a_wdata | input | WIDTH | Port A write word for mail1 |
| a_rdata | output | WIDTH | Port A read register, loaded from mail2 |
| mbf1_n | output | 1 | Mail1 flag in clk_a domain, low while mail1 is occupied |
| b_en | input | 1 | Port B access enable |
| b_wr | input | 1 | Port B direction: 1 write, 0 read |
| b_size | input | 2 | Port B size code, 2'b11 selects the mailboxes |
| b_wdata | input | WIDTH | Port B write word for mail2 |
| b_rdata | output | WIDTH | Port B read register, loaded from mail1 |
| mbf2_n | output | 1 | Mail2 flag in clk_b domain, low while mail2 is occupied |

## Verification
Random words travel both ways through full write-then-read round trips. Between round trips come decoy accesses: port A traffic with the select low, and port B traffic with random non-mailbox size codes. A difference between the word read and the word written would show a decode fault or a register that updates when it should not. Directed cases offer a second write while the flag is low, to show that the first word survives and the write is dropped. Other directed cases issue reads before the word has crossed, to show that a read output or flag does not react early. A timed sample of `mbf1_n` around the read separates a correct two-stage crossing from one that is too short or never completes.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam logic [1:0] MBX_SIZE_CODE = 2'b11;

  function automatic logic b_is_mbx(input logic [1:0] size);
    return size == MBX_SIZE_CODE;
  endfunction
endpackage

// File: rtl/mbx_bit_sync.sv
module mbx_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
  parameter int WIDTH       = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic             w_clk,
  input  logic             r_clk,
  input  logic             rst_n,
  input  logic             w_req,
  input  logic [WIDTH-1:0] w_data,
  output logic             w_full_n,
  input  logic             r_req,
  output logic [WIDTH-1:0] r_data
);
  logic             set_tog;
  logic             clr_tog;
  logic             set_seen;
  logic             clr_seen;
  logic             r_avail;
  logic [WIDTH-1:0] mail;

  mbx_bit_sync #(.STAGES(SYNC_STAGES)) u_set_sync (
    .clk(r_clk), .rst_n(rst_n), .d(set_tog), .q(set_seen)
  );

  mbx_bit_sync #(.STAGES(SYNC_STAGES)) u_clr_sync (
    .clk(w_clk), .rst_n(rst_n), .d(clr_tog), .q(clr_seen)
  );

  // writer domain: occupied while our toggle differs from the returned clear
  assign w_full_n = ~(set_tog ^ clr_seen);

  always_ff @(posedge w_clk or negedge rst_n) begin
    if (!rst_n) begin
      set_tog <= 1'b0;
      mail    <= '0;
    end else if (w_req && w_full_n) begin
      set_tog <= ~set_tog;
      mail    <= w_data;
    end
  end

  // reader domain: a word is available once its set toggle has crossed
  assign r_avail = set_seen ^ clr_tog;

  always_ff @(posedge r_clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_tog <= 1'b0;
      r_data  <= '0;
    end else if (r_req && r_avail) begin
      clr_tog <= ~clr_tog;
      r_data  <= mail;
    end
  end

  // R2 / R5: an accepted write leaves the flag low
  p_write_sets_flag_r2: assert property (@(posedge w_clk) disable iff (!rst_n)
    w_req && w_full_n |=> !w_full_n);

  // R3 / R6: a held word is never overwritten
  p_full_holds_word_r3: assert property (@(posedge w_clk) disable iff (!rst_n)
    !w_full_n |=> $stable(mail));

  // R4 / R7: a read of an available word consumes it
  p_read_consumes_r4: assert property (@(posedge r_clk) disable iff (!rst_n)
    r_req && r_avail |=> !r_avail);

  // R9: no read output change without an available word
  p_early_read_quiet_r9: assert property (@(posedge r_clk) disable iff (!rst_n)
    !r_avail |=> $stable(r_data));
endmodule

// File: rtl/mbx_pair.sv
module mbx_pair
  import mbx_pkg::*;
#(
  parameter int WIDTH       = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_a,
  input  logic             clk_b,
  input  logic             rst_n,
  input  logic             a_en,
  input  logic             a_wr,
  input  logic             a_mbx_sel,
  input  logic [WIDTH-1:0] a_wdata,
  output logic [WIDTH-1:0] a_rdata,
  output logic             mbf1_n,
  input  logic             b_en,
  input  logic             b_wr,
  input  logic [1:0]       b_size,
  input  logic [WIDTH-1:0] b_wdata,
  output logic [WIDTH-1:0] b_rdata,
  output logic             mbf2_n
);
  logic a_hit, b_hit;
  logic a_mb_wr, a_mb_rd, b_mb_wr, b_mb_rd;

  assign a_hit   = a_en && a_mbx_sel;
  assign b_hit   = b_en && b_is_mbx(b_size);
  assign a_mb_wr = a_hit &&  a_wr;
  assign a_mb_rd = a_hit && !a_wr;
  assign b_mb_wr = b_hit &&  b_wr;
  assign b_mb_rd = b_hit && !b_wr;

  // mail1: A -> B
  mbx_channel #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_mail1 (
    .w_clk(clk_a), .r_clk(clk_b), .rst_n(rst_n),
    .w_req(a_mb_wr), .w_data(a_wdata), .w_full_n(mbf1_n),
    .r_req(b_mb_rd), .r_data(b_rdata)
  );

  // mail2: B -> A
  mbx_channel #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_mail2 (
    .w_clk(clk_b), .r_clk(clk_a), .rst_n(rst_n),
    .w_req(b_mb_wr), .w_data(b_wdata), .w_full_n(mbf2_n),
    .r_req(a_mb_rd), .r_data(a_rdata)
  );

  // R8: non-mailbox traffic leaves the read registers alone
  p_a_bypass_quiet_r8: assert property (@(posedge clk_a) disable iff (!rst_n)
    !a_mbx_sel |=> $stable(a_rdata));
  p_b_bypass_quiet_r8: assert property (@(posedge clk_b) disable iff (!rst_n)
    !b_is_mbx(b_size) |=> $stable(b_rdata));
endmodule

// File: tb/mbx_pair_bench.sv
`timescale 1ns/1ps
module mbx_pair_bench;
  localparam int  W      = 36;
  localparam time CLK_A  = 10ns;
  localparam time CLK_B  = 14ns;

  logic clk_a = 0, clk_b = 0, rst_n = 0;
  logic a_en = 0, a_wr = 0, a_mbx_sel = 0;
  logic b_en = 0, b_wr = 0;
  logic [1:0] b_size = 0;
  logic [W-1:0] a_wdata = 0, b_wdata = 0;
  logic [W-1:0] a_rdata, b_rdata;
  logic mbf1_n, mbf2_n;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_A/2) clk_a = ~clk_a;
  initial begin #1ns; forever #(CLK_B/2) clk_b = ~clk_b; end

  mbx_pair #(.WIDTH(W), .SYNC_STAGES(2)) u_mbx_pair (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
    .a_en(a_en), .a_wr(a_wr), .a_mbx_sel(a_mbx_sel), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .mbf1_n(mbf1_n),
    .b_en(b_en), .b_wr(b_wr), .b_size(b_size), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .mbf2_n(mbf2_n)
  );

  function automatic bit exp_b_mbx(input logic [1:0] s);
    return s == 2'b11;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic a_op(input bit wr, input bit sel, input logic [W-1:0] d);
    @(negedge clk_a);
    a_en = 1; a_wr = wr; a_mbx_sel = sel; a_wdata = d;
    @(negedge clk_a);
    a_en = 0; a_wr = 0; a_mbx_sel = 0;
  endtask

  task automatic b_op(input bit wr, input logic [1:0] sz, input logic [W-1:0] d);
    @(negedge clk_b);
    b_en = 1; b_wr = wr; b_size = sz; b_wdata = d;
    @(negedge clk_b);
    b_en = 0; b_wr = 0; b_size = 0;
  endtask

  task automatic wait_a(input int n); repeat (n) @(negedge clk_a); endtask
  task automatic wait_b(input int n); repeat (n) @(negedge clk_b); endtask

  initial begin
    logic [W-1:0] d0, d1, keep_a, keep_b;
    logic [1:0] sz;
    void'($urandom(32'h5eed_0a1b));
    #25ns;
    // R1 during reset
    chk("R1", {34'd0, mbf1_n, mbf2_n}, {34'd0, 2'b11});
    rst_n = 1;
    wait_a(2);
    chk("R1", a_rdata, '0);
    chk("R1", b_rdata, '0);
    chk("R1", {34'd0, mbf1_n, mbf2_n}, {34'd0, 2'b11});

    // R9: read with nothing pending
    b_op(0, 2'b11, '0);
    chk("R9", b_rdata, '0);
    a_op(0, 1, '0);
    chk("R9", a_rdata, '0);

    // R2, R3, R9, R4, R10 directed
    d0 = 36'h1_2345_6789; d1 = 36'hF_EDCB_A987;
    a_op(1, 1, d0);
    chk("R2", {35'd0, mbf1_n}, '0);
    b_op(0, 2'b11, '0);               // too early to see the word
    chk("R9", b_rdata, '0);
    a_op(1, 1, d1);                   // dropped
    chk("R3", {35'd0, mbf1_n}, '0);
    wait_b(3);
    b_op(0, 2'b01, '0);               // not a mailbox code
    chk("R8", b_rdata, '0);
    @(negedge clk_b); b_en = 1; b_wr = 0; b_size = 2'b11;
    @(posedge clk_b); #1ns; b_en = 0; b_size = 0;
    @(posedge clk_a); @(negedge clk_a);
    chk("R10", {35'd0, mbf1_n}, '0);
    chk("R3", b_rdata, d0);
    chk("R4", b_rdata, d0);
    wait_a(3);
    chk("R10", {35'd0, mbf1_n}, 36'd1);

    // R5, R6, R7 directed
    b_op(1, 2'b11, d1);
    chk("R5", {35'd0, mbf2_n}, '0);
    b_op(1, 2'b11, d0);               // dropped
    wait_a(3);
    a_op(0, 0, '0);                   // select low: FIFO path
    chk("R8", a_rdata, '0);
    a_op(0, 1, '0);
    chk("R6", a_rdata, d1);
    chk("R7", a_rdata, d1);
    wait_b(4);
    chk("R7", {35'd0, mbf2_n}, 36'd1);

    // random round trips with decoys
    for (int i = 0; i < 40; i++) begin
      d0 = {$urandom, $urandom} ; d1 = {$urandom, $urandom};
      keep_b = b_rdata; keep_a = a_rdata;
      a_op(1, 0, d1);                 // decoy write, select low
      chk("R8", {35'd0, mbf1_n}, 36'd1);
      a_op(1, 1, d0);
      chk("R2", {35'd0, mbf1_n}, '0);
      sz = 2'($urandom_range(0, 2));
      b_op($urandom_range(0, 1), sz, d1);   // decoy, non-mailbox code
      if (!exp_b_mbx(sz)) chk("R8", {34'd0, mbf2_n, 1'b0}, {34'd0, 1'b1, 1'b0});
      wait_b(3);
      chk("R8", b_rdata, keep_b);
      b_op(0, 2'b11, '0);
      chk("R4", b_rdata, d0);
      b_op(1, 2'b11, d1);
      chk("R5", {35'd0, mbf2_n}, '0);
      wait_a(3);
      chk("R8", a_rdata, keep_a);
      a_op(0, 1, '0);
      chk("R7", a_rdata, d1);
      wait_a(4); wait_b(4);
      chk("R4", {34'd0, mbf1_n, mbf2_n}, {34'd0, 2'b11});
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk_a);
        fails++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule